// File: doc/BRIEF.md
# SIMD Node Control Sequencer

This block sequences one node of a mesh of processing nodes that all listen to a single broadcast instruction line. Every node shifts in the same serial frames. Each node then decides for itself whether to act on a frame, based on a local enable flag. The block also moves a word serially to or from one of its four mesh neighbours. On request it can go autonomous: it runs a routine from its own memory until it reads a marker word.

The datapath is outside this block. An instruction the block does not decode itself is passed on as a one-cycle execute strobe together with the instruction word. The memory is a plain synchronous read port: data returns in the cycle after the read enable.

Top module: `simd_node_ctrl`

## Requirements
- R1: A frame on `gbl_din` is a single start bit of 1 followed by 16 instruction bits, MSB first, on an idle-low line. The opcode is bits [15:12]. The decoded effect appears in the second cycle after the clock edge that samples the last bit.
- R2: After reset, `flag`, `local_mode`, `exec_stb`, `mem_rd_en`, `xchg_done` and `nb_out` are all low.
- R3: Opcode 1 sets `flag` and opcode 2 clears it. Both take effect whatever the flag's current state.
- R4: Opcodes 6 to 15 produce a one-cycle `exec_stb`, with `exec_op` equal to the instruction word, only when `flag` is set. Opcodes 0 and 5 have no effect in global mode.
- R5: Opcode 3 exchanges a word with direction code bits [1:0] (0 north, 1 east, 2 south, 3 west). `xchg_tx` is shifted out MSB first on `nb_out[dir]`, one bit per cycle for 16 cycles. All other `nb_out` lines stay low, and all are low outside an exchange.
- R6: During an exchange, the word arriving on the opposite port (`dir` XOR 2) is shifted in MSB first. It appears on `xchg_rx` with a one-cycle `xchg_done` one cycle after the last bit.
- R7: When the `link_en` bit of the source port is low, the received word is all zeros.
- R8: Opcode 4 with address in bits [7:0] enters autonomous mode (`local_mode` high) at that address only when `flag` is set. Otherwise it is ignored.
- R9: In autonomous mode the node reads consecutive addresses and executes what it reads as in R3 to R5. Opcode 4 read from memory jumps when `flag` is set.
- R10: Reading the marker word 16'hFFFF returns the node to global mode.
- R11: In autonomous mode every broadcast frame is ignored except opcode 5, which returns the node to global mode.
- R12: A high `recap` forces `local_mode` low in the next cycle and aborts any exchange.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the broadcast bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gbl_din | input | 1 | Serial broadcast instruction line |
| recap | input | 1 | Forced return to global control |
| link_en | input | 4 | Per-port input link enable (N,E,S,W = bits 0..3) |
| nb_in | input | 4 | Serial inputs from neighbours |
| nb_out | output | 4 | Serial outputs to neighbours |
| xchg_tx | input | WORD_W | Word to send in an exchange |
| xchg_rx | output | WORD_W | Last word received |
| xchg_done | output | 1 | One-cycle end-of-exchange pulse |
| mem_rd_en | output | 1 | Local memory read enable |
| mem_addr | output | ADDR_W | Local memory read address |
| mem_rdata | input | 16 | Local memory read data, one cycle after enable |
| flag | output | 1 | Local enable flag |
| local_mode | output | 1 | High while autonomous |
| exec_stb | output | 1 | Execute strobe for non-control opcodes |
| exec_op | output | 16 | Instruction word for the datapath |

## Verification
A frame counter that slips by one bit corrupts the opcode. This shows at `flag` or `exec_stb` two cycles after the frame's final bit. A wrong mode or state bit shows as `local_mode` or `mem_rd_en` misbehaving within a cycle or two of the triggering frame, memory word or `recap`. A wrong exchange counter or port select shows at once on `nb_out` during the 16 shift cycles, or in `xchg_rx` one cycle after them.

// File: rtl/simd_node_pkg.sv
package simd_node_pkg;
  localparam int unsigned INSN_W = 16;
  localparam logic [3:0] OP_NOP   = 4'd0;
  localparam logic [3:0] OP_SETF  = 4'd1;
  localparam logic [3:0] OP_CLRF  = 4'd2;
  localparam logic [3:0] OP_XCHG  = 4'd3;
  localparam logic [3:0] OP_GOLOC = 4'd4;
  localparam logic [3:0] OP_RECAP = 4'd5;
  localparam logic [INSN_W-1:0] MARKER_WORD = 16'hFFFF;

  typedef enum logic [1:0] {S_GLB, S_FETCH, S_EXEC, S_XCHG} seq_st_e;
endpackage

// File: rtl/simd_glb_rx.sv
module simd_glb_rx #(
  parameter int unsigned FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               din,
  output logic               frm_vld,
  output logic [FRAME_W-1:0] frm
);
  localparam int unsigned CNT_W = $clog2(FRAME_W);

  logic               busy_q, busy_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [FRAME_W-1:0] sh_q, sh_d, frm_q, frm_d;
  logic               vld_q, vld_d;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    frm_d  = frm_q;
    vld_d  = 1'b0;
    if (!busy_q) begin
      if (din) begin
        busy_d = 1'b1;
        cnt_d  = '0;
      end
    end else begin
      sh_d  = {sh_q[FRAME_W-2:0], din};
      cnt_d = cnt_q + CNT_W'(1);
      if (cnt_q == CNT_W'(FRAME_W-1)) begin
        busy_d = 1'b0;
        vld_d  = 1'b1;
        frm_d  = sh_d;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      sh_q   <= '0;
      frm_q  <= '0;
      vld_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      frm_q  <= frm_d;
      vld_q  <= vld_d;
    end
  end

  assign frm_vld = vld_q;
  assign frm     = frm_q;

  AST_FRAME_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    frm_vld |=> !frm_vld); // R1
endmodule

// File: rtl/simd_xchg.sv
module simd_xchg #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abort,
  input  logic [1:0]        dir,
  input  logic [WORD_W-1:0] tx_word,
  input  logic [3:0]        link_en,
  input  logic [3:0]        nb_in,
  output logic [3:0]        nb_out,
  output logic              done,
  output logic [WORD_W-1:0] rx_word
);
  localparam int unsigned CNT_W = $clog2(WORD_W);

  logic              busy_q, busy_d, done_q, done_d;
  logic [1:0]        dir_q, dir_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [WORD_W-1:0] tx_q, tx_d, rsh_q, rsh_d, rx_q, rx_d;
  logic [1:0]        src;
  logic              in_bit;

  assign src    = dir_q ^ 2'b10;
  assign in_bit = nb_in[src] & link_en[src];

  always_comb begin
    busy_d = busy_q;
    done_d = 1'b0;
    dir_d  = dir_q;
    cnt_d  = cnt_q;
    tx_d   = tx_q;
    rsh_d  = rsh_q;
    rx_d   = rx_q;
    if (abort) begin
      busy_d = 1'b0;
    end else if (start && !busy_q) begin
      busy_d = 1'b1;
      dir_d  = dir;
      cnt_d  = '0;
      tx_d   = tx_word;
    end else if (busy_q) begin
      tx_d  = {tx_q[WORD_W-2:0], 1'b0};
      rsh_d = {rsh_q[WORD_W-2:0], in_bit};
      cnt_d = cnt_q + CNT_W'(1);
      if (cnt_q == CNT_W'(WORD_W-1)) begin
        busy_d = 1'b0;
        done_d = 1'b1;
        rx_d   = rsh_d;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      dir_q  <= 2'd0;
      cnt_q  <= '0;
      tx_q   <= '0;
      rsh_q  <= '0;
      rx_q   <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      dir_q  <= dir_d;
      cnt_q  <= cnt_d;
      tx_q   <= tx_d;
      rsh_q  <= rsh_d;
      rx_q   <= rx_d;
    end
  end

  always_comb begin
    nb_out = '0;
    if (busy_q) nb_out[dir_q] = tx_q[WORD_W-1];
  end

  assign done    = done_q;
  assign rx_word = rx_q;

  AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(nb_out)); // R5
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> nb_out == 4'b0000); // R5
endmodule

// File: rtl/simd_node_seq.sv
module simd_node_seq
  import simd_node_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frm_vld,
  input  logic [INSN_W-1:0] frm,
  input  logic              recap,
  input  logic [INSN_W-1:0] mem_rdata,
  input  logic              xchg_done,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              xchg_start,
  output logic              xchg_abort,
  output logic [1:0]        xchg_dir,
  output logic              flag,
  output logic              local_mode,
  output logic              exec_stb,
  output logic [INSN_W-1:0] exec_op
);
  seq_st_e           state_q, state_d;
  logic              flag_q, flag_d, auto_q, auto_d, stb_q, stb_d;
  logic [ADDR_W-1:0] pc_q, pc_d;
  logic [INSN_W-1:0] op_q, op_d, insn;
  logic [3:0]        opc;
  logic              run, recap_frm;

  assign insn      = (state_q == S_EXEC) ? mem_rdata : frm;
  assign opc       = insn[INSN_W-1:INSN_W-4];
  assign recap_frm = frm_vld && (frm[INSN_W-1:INSN_W-4] == OP_RECAP);

  always_comb begin
    state_d    = state_q;
    flag_d     = flag_q;
    auto_d     = auto_q;
    pc_d       = pc_q;
    stb_d      = 1'b0;
    op_d       = op_q;
    xchg_start = 1'b0;
    xchg_abort = 1'b0;
    run        = 1'b0;
    if (recap || (auto_q && recap_frm)) begin
      state_d    = S_GLB;
      auto_d     = 1'b0;
      xchg_abort = 1'b1;
    end else begin
      unique case (state_q)
        S_GLB:   run = frm_vld;
        S_FETCH: begin
          state_d = S_EXEC;
          pc_d    = pc_q + ADDR_W'(1);
        end
        S_EXEC: begin
          if (mem_rdata == MARKER_WORD) begin
            state_d = S_GLB;
            auto_d  = 1'b0;
          end else begin
            state_d = S_FETCH;
            run     = 1'b1;
          end
        end
        S_XCHG: if (xchg_done) state_d = auto_q ? S_FETCH : S_GLB;
        default: state_d = S_GLB;
      endcase
      if (run) begin
        case (opc)
          OP_SETF: flag_d = 1'b1;
          OP_CLRF: flag_d = 1'b0;
          OP_XCHG: begin
            xchg_start = 1'b1;
            state_d    = S_XCHG;
          end
          OP_GOLOC: if (flag_q) begin
            auto_d  = 1'b1;
            pc_d    = insn[ADDR_W-1:0];
            state_d = S_FETCH;
          end
          OP_NOP, OP_RECAP: ;
          default: if (flag_q) begin
            stb_d = 1'b1;
            op_d  = insn;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_GLB;
      flag_q  <= 1'b0;
      auto_q  <= 1'b0;
      pc_q    <= '0;
      stb_q   <= 1'b0;
      op_q    <= '0;
    end else begin
      state_q <= state_d;
      flag_q  <= flag_d;
      auto_q  <= auto_d;
      pc_q    <= pc_d;
      stb_q   <= stb_d;
      op_q    <= op_d;
    end
  end

  assign mem_rd_en  = (state_q == S_FETCH);
  assign mem_addr   = pc_q;
  assign xchg_dir   = insn[1:0];
  assign flag       = flag_q;
  assign local_mode = auto_q;
  assign exec_stb   = stb_q;
  assign exec_op    = op_q;

  AST_RECAP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    recap |=> !local_mode); // R12
  AST_EXEC_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    exec_stb |-> flag); // R4
  AST_FETCH_ONLY_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> local_mode); // R9
  AST_MARKER_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_EXEC && mem_rdata == MARKER_WORD) |=> !local_mode); // R10
endmodule

// File: rtl/simd_node_ctrl.sv
module simd_node_ctrl
  import simd_node_pkg::*;
#(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gbl_din,
  input  logic              recap,
  input  logic [3:0]        link_en,
  input  logic [3:0]        nb_in,
  output logic [3:0]        nb_out,
  input  logic [WORD_W-1:0] xchg_tx,
  output logic [WORD_W-1:0] xchg_rx,
  output logic              xchg_done,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [INSN_W-1:0] mem_rdata,
  output logic              flag,
  output logic              local_mode,
  output logic              exec_stb,
  output logic [INSN_W-1:0] exec_op
);
  logic              frm_vld, x_start, x_abort;
  logic [INSN_W-1:0] frm;
  logic [1:0]        x_dir;

  simd_glb_rx #(.FRAME_W(INSN_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .din(gbl_din), .frm_vld(frm_vld), .frm(frm)
  );

  simd_node_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .frm_vld(frm_vld), .frm(frm), .recap(recap),
    .mem_rdata(mem_rdata), .xchg_done(xchg_done), .mem_rd_en(mem_rd_en),
    .mem_addr(mem_addr), .xchg_start(x_start), .xchg_abort(x_abort),
    .xchg_dir(x_dir), .flag(flag), .local_mode(local_mode),
    .exec_stb(exec_stb), .exec_op(exec_op)
  );

  simd_xchg #(.WORD_W(WORD_W)) u_xchg (
    .clk(clk), .rst_n(rst_n), .start(x_start), .abort(x_abort), .dir(x_dir),
    .tx_word(xchg_tx), .link_en(link_en), .nb_in(nb_in), .nb_out(nb_out),
    .done(xchg_done), .rx_word(xchg_rx)
  );
endmodule

// File: tb/sim_simd_node_ctrl.sv
module sim_simd_node_ctrl;
  logic        clk, rst_n, gbl_din, recap;
  logic [3:0]  link_en, nb_in, nb_out;
  logic [15:0] xchg_tx, xchg_rx, mem_rdata, exec_op;
  logic        xchg_done, mem_rd_en, flag, local_mode, exec_stb;
  logic [7:0]  mem_addr;
  logic [15:0] mem [256];
  int          n_run = 0, n_fail = 0, exec_cnt = 0;
  logic [15:0] last_op = '0;
  bit          finished = 0;

  simd_node_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .gbl_din(gbl_din), .recap(recap),
    .link_en(link_en), .nb_in(nb_in), .nb_out(nb_out), .xchg_tx(xchg_tx),
    .xchg_rx(xchg_rx), .xchg_done(xchg_done), .mem_rd_en(mem_rd_en),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .flag(flag),
    .local_mode(local_mode), .exec_stb(exec_stb), .exec_op(exec_op)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) if (mem_rd_en) mem_rdata <= mem[mem_addr];
  always @(negedge clk) if (exec_stb) begin exec_cnt++; last_op = exec_op; end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_frame(input logic [15:0] w);
    @(negedge clk) gbl_din = 1'b1;
    for (int i = 15; i >= 0; i--) begin @(negedge clk) gbl_din = w[i]; end
    @(negedge clk) gbl_din = 1'b0;
  endtask

  task automatic t_reset;
    chk("R2 flag", flag, 0);
    chk("R2 local_mode", local_mode, 0);
    chk("R2 outputs", {exec_stb, mem_rd_en, xchg_done, nb_out}, 0);
  endtask

  task automatic t_flag_exec;
    int c0;
    c0 = exec_cnt;
    send_frame(16'h7111);
    @(negedge clk);
    chk("R4 no strobe while flag low", exec_cnt - c0, 0);
    send_frame(16'h1000);
    chk("R1 no effect before decode cycle", flag, 0);
    @(negedge clk);
    chk("R3 set flag", flag, 1);
    send_frame(16'h1000);
    @(negedge clk);
    chk("R3 set while set", flag, 1);
    send_frame(16'hB2C4);
    @(negedge clk);
    chk("R4 strobe", exec_stb, 1);
    chk("R4 exec_op", exec_op, 16'hB2C4);
    send_frame(16'h0000);
    send_frame(16'h5000);
    @(negedge clk);
    chk("R4 nop/recap-op silent", exec_cnt - c0, 1);
    send_frame(16'h2000);
    @(negedge clk);
    chk("R3 clear flag", flag, 0);
    send_frame(16'h2000);
    @(negedge clk);
    chk("R3 clear while clear", flag, 0);
  endtask

  task automatic t_xchg(input logic [1:0] d, input logic [15:0] tx,
                        input logic [15:0] pat, input logic [3:0] len,
                        input logic [15:0] exp_rx);
    int bad = 0;
    logic [1:0] s;
    s = d ^ 2'b10;
    xchg_tx = tx;
    link_en = len;
    send_frame({14'h0C00, d});
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      nb_in = ~{4{pat[15-k]}};
      nb_in[s] = pat[15-k];
      if (nb_out !== (tx[15-k] ? (4'b0001 << d) : 4'b0000)) bad++;
    end
    chk("R5 serial out on one port", bad, 0);
    @(negedge clk);
    nb_in = '0;
    chk("R6 done pulse", xchg_done, 1);
    chk("R6/R7 received word", xchg_rx, exp_rx);
    chk("R5 quiet after exchange", nb_out, 0);
    link_en = 4'hF;
  endtask

  task automatic t_golocal_noflag;
    send_frame(16'h4010);
    @(negedge clk);
    chk("R8 ignored when flag low", {local_mode, mem_rd_en}, 0);
  endtask

  task automatic t_local_prog;
    int c0;
    c0 = exec_cnt;
    send_frame(16'h1000);
    send_frame(16'h4010);
    @(negedge clk);
    chk("R8 local_mode", local_mode, 1);
    chk("R9 first fetch", {mem_rd_en, mem_addr}, {1'b1, 8'h10});
    repeat (12) @(negedge clk);
    chk("R10 marker returns", local_mode, 0);
    chk("R9 clear from memory", flag, 0);
    chk("R9 strobe count", exec_cnt - c0, 1);
    chk("R9 strobe word", last_op, 16'h7ABC);
  endtask

  task automatic t_ignore_and_recap_frame;
    int c0;
    send_frame(16'h1000);
    send_frame(16'h4020);
    c0 = exec_cnt;
    send_frame(16'h2000);
    send_frame(16'h7000);
    @(negedge clk);
    chk("R11 frames ignored flag", flag, 1);
    chk("R11 frames ignored exec", exec_cnt - c0, 0);
    chk("R9 jump loop stays local", local_mode, 1);
    send_frame(16'h5000);
    @(negedge clk);
    chk("R11 recapture frame", local_mode, 0);
  endtask

  task automatic t_recap_strobe;
    send_frame(16'h4020);
    repeat (5) @(negedge clk);
    chk("R12 local before strobe", local_mode, 1);
    recap = 1'b1;
    @(negedge clk);
    recap = 1'b0;
    chk("R12 strobe wins", local_mode, 0);
    repeat (3) @(negedge clk);
    chk("R12 stays global", {local_mode, mem_rd_en}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    mem[8'h10] = 16'h7ABC; mem[8'h11] = 16'h2000;
    mem[8'h12] = 16'h7123; mem[8'h13] = 16'hFFFF;
    mem[8'h20] = 16'h4020;
    rst_n = 1'b0; gbl_din = 1'b0; recap = 1'b0;
    link_en = 4'hF; nb_in = '0; xchg_tx = '0; mem_rdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_flag_exec();
    t_xchg(2'd0, 16'hA5C3, 16'h1E96, 4'hF, 16'h1E96);
    t_xchg(2'd1, 16'h8001, 16'hFFFF, 4'b0111, 16'h0000);
    t_golocal_noflag();
    t_local_prog();
    t_ignore_and_recap_frame();
    t_recap_strobe();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule